// File: doc/BRIEF.md
# Fan-Out Primary Feedback Selector

This block sits beside a primary controller whose output is spread across several parallel secondary controllers. Each execution it decides two things: whether the primary must initialise, and which single value the primary should use as its external reset feedback. It works from status and maxima that have already been collected across the secondary chain. The block does not compute those per-secondary values itself.

The initialise command is raised for a short, fixed number of executions after any secondary joins or leaves control. It is also raised for as long as no secondary is in control. A delayed copy of the command marks that initialisation has been under way for a while. The feedback is then taken from one of four sources in a fixed priority order. This keeps the primary's integral action from winding up when secondaries are limited. It also lines the primary up without a bump when the set of active secondaries changes.

All state advances only on a one-cycle execute strobe, and both timers count executions rather than clocks. Values are signed fixed point: 16 bits by default, 8 of them fraction bits, which covers -50 % to +150 %. Data values pass through unchanged.

Top module: `fo_fbk_select`

## Requirements
- R1: On any execution where `any_in_ctl` is 0, `init` is 1 after that execution.
- R2: An execution that sees `ctl_chg` at 1 after it was 0 on the previous execution starts a one-shot. The one-shot holds `init` at 1 for SHOT_LEN executions (default 2), counting the triggering one. A `ctl_chg` that stays at 1 does not start it again. A new rising edge while the one-shot runs reloads it.
- R3: `init_dly` is 1 after an execution only if `init` has been 1 on DLY_LEN+1 consecutive executions, this one included (default DLY_LEN = 1). It drops on the same execution on which `init` drops.
- R4: When `any_in_ctl` is 0, `fbk_out` equals `pos_max`. This rule has the highest priority.
- R5: Otherwise, when `init` is 1 and `init_dly` is 0, `fbk_out` equals `prim_out`.
- R6: Otherwise, when `init_dly` is 1, `fbk_out` equals `pos_ctl_max`.
- R7: Otherwise, when `any_not_lo` and `any_not_hi` are both 1, `fbk_out` equals `prim_out`.
- R8: Otherwise (no init, and either every secondary is at its low limit or every secondary is at its high limit), `fbk_out` equals `fbk_max`.
- R9: On a clock without `exec_en`, no output changes and no internal timer moves.
- R10: After reset, `fbk_out` is 0 and `init` and `init_dly` are 0. The change detector treats the previous `ctl_chg` as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_en | input | 1 | One-cycle execute strobe |
| any_in_ctl | input | 1 | At least one secondary is in control |
| any_not_lo | input | 1 | At least one in-control secondary is clear of its low limit |
| any_not_hi | input | 1 | At least one in-control secondary is clear of its high limit |
| ctl_chg | input | 1 | Some secondary changed in-control status |
| fbk_max | input | DATA_W | Highest back-calculated feedback among secondaries |
| pos_max | input | DATA_W | Highest position among all secondaries |
| pos_ctl_max | input | DATA_W | Highest position among in-control secondaries |
| prim_out | input | DATA_W | Present primary controller output |
| fbk_out | output | DATA_W | Selected reset feedback, signed, FRAC_W fraction bits |
| init | output | 1 | Primary initialise command |
| init_dly | output | 1 | Initialise command after the delay-on timer |

## Verification
The hardest case to reach is the short window in which `init` is on and `init_dly` is still off while some secondary is in control. It lasts one execution per rising edge of `ctl_chg`. Random stimulus keeps `ctl_chg` mostly low and `any_in_ctl` mostly high, so that isolated edges happen often. Directed sequences add a single edge, a held-high change input, a retrigger inside the one-shot, and clocks without the strobe placed between executions.

// File: rtl/fo_pkg.sv
package fo_pkg;
   typedef enum logic [1:0] {
      SRC_POS_ALL = 2'd0,
      SRC_PRIM    = 2'd1,
      SRC_POS_CTL = 2'd2,
      SRC_FBK_MAX = 2'd3
   } fo_src_e;

   function automatic fo_src_e fo_pick(input logic in_ctl, input logic ini,
                                       input logic dly, input logic not_lo,
                                       input logic not_hi);
      if (!in_ctl)             return SRC_POS_ALL;
      else if (ini && !dly)    return SRC_PRIM;
      else if (dly)            return SRC_POS_CTL;
      else if (not_lo && not_hi) return SRC_PRIM;
      else                     return SRC_FBK_MAX;
   endfunction
endpackage

// File: rtl/fo_oneshot.sv
module fo_oneshot #(
   parameter int SHOT_LEN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic trig,
   output logic active
);
   localparam int CW = (SHOT_LEN < 2) ? 1 : $clog2(SHOT_LEN + 1);
   localparam logic [CW-1:0] RELOAD = CW'(SHOT_LEN - 1);

   generate
      if (SHOT_LEN < 1) begin : g_bad_len
         $error("fo_oneshot: SHOT_LEN must be at least 1");
      end
   endgenerate

   logic          prev_q;
   logic [CW-1:0] cnt_q;
   logic          rise;

   assign rise   = trig && !prev_q;
   assign active = rise || (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         cnt_q  <= '0;
      end else if (en) begin
         prev_q <= trig;
         if (rise)              cnt_q <= RELOAD;
         else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      end
   end

   AST_SHOT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cnt_q) && $stable(prev_q));   // R9
endmodule

// File: rtl/fo_delay_on.sv
module fo_delay_on #(
   parameter int DLY_LEN = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic din,
   output logic dout
);
   generate
      if (DLY_LEN < 0) begin : g_bad_len
         $error("fo_delay_on: DLY_LEN must not be negative");
      end
      if (DLY_LEN == 0) begin : g_pass
         assign dout = din;
      end else begin : g_timer
         localparam int CW = $clog2(DLY_LEN + 1);
         localparam logic [CW-1:0] LIMIT = CW'(DLY_LEN);
         logic [CW-1:0] on_q;

         assign dout = din && (on_q >= LIMIT);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              on_q <= '0;
            else if (en) begin
               if (!din)             on_q <= '0;
               else if (on_q < LIMIT) on_q <= on_q + 1'b1;
            end
         end

         AST_DLY_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> $stable(on_q));   // R9
      end
   endgenerate
endmodule

// File: rtl/fo_select.sv
module fo_select
   import fo_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic                     in_ctl,
   input  logic                     ini,
   input  logic                     dly,
   input  logic                     not_lo,
   input  logic                     not_hi,
   input  logic signed [DATA_W-1:0] v_fbk_max,
   input  logic signed [DATA_W-1:0] v_pos_max,
   input  logic signed [DATA_W-1:0] v_pos_ctl,
   input  logic signed [DATA_W-1:0] v_prim,
   output logic signed [DATA_W-1:0] v_out
);
   fo_src_e src;

   always_comb begin
      src = fo_pick(in_ctl, ini, dly, not_lo, not_hi);
      unique case (src)
         SRC_POS_ALL: v_out = v_pos_max;
         SRC_PRIM:    v_out = v_prim;
         SRC_POS_CTL: v_out = v_pos_ctl;
         default:     v_out = v_fbk_max;
      endcase
   end
endmodule

// File: rtl/fo_fbk_select.sv
module fo_fbk_select #(
   parameter int DATA_W   = 16,
   parameter int FRAC_W   = 8,
   parameter int SHOT_LEN = 2,
   parameter int DLY_LEN  = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     exec_en,
   input  logic                     any_in_ctl,
   input  logic                     any_not_lo,
   input  logic                     any_not_hi,
   input  logic                     ctl_chg,
   input  logic signed [DATA_W-1:0] fbk_max,
   input  logic signed [DATA_W-1:0] pos_max,
   input  logic signed [DATA_W-1:0] pos_ctl_max,
   input  logic signed [DATA_W-1:0] prim_out,
   output logic signed [DATA_W-1:0] fbk_out,
   output logic                     init,
   output logic                     init_dly
);
   generate
      if (DATA_W < 4 || FRAC_W < 0 || FRAC_W >= DATA_W) begin : g_bad_fmt
         $error("fo_fbk_select: need DATA_W >= 4 and 0 <= FRAC_W < DATA_W");
      end
   endgenerate

   logic                     shot;
   logic                     init_n;
   logic                     dly_n;
   logic signed [DATA_W-1:0] fbk_n;

   fo_oneshot #(.SHOT_LEN(SHOT_LEN)) u_shot (
      .clk(clk), .rst_n(rst_n), .en(exec_en), .trig(ctl_chg), .active(shot)
   );

   assign init_n = shot || !any_in_ctl;

   fo_delay_on #(.DLY_LEN(DLY_LEN)) u_dly (
      .clk(clk), .rst_n(rst_n), .en(exec_en), .din(init_n), .dout(dly_n)
   );

   fo_select #(.DATA_W(DATA_W)) u_sel (
      .in_ctl(any_in_ctl), .ini(init_n), .dly(dly_n),
      .not_lo(any_not_lo), .not_hi(any_not_hi),
      .v_fbk_max(fbk_max), .v_pos_max(pos_max), .v_pos_ctl(pos_ctl_max),
      .v_prim(prim_out), .v_out(fbk_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fbk_out  <= '0;
         init     <= 1'b0;
         init_dly <= 1'b0;
      end else if (exec_en) begin
         fbk_out  <= fbk_n;
         init     <= init_n;
         init_dly <= dly_n;
      end
   end

   AST_NONE_IN_CTL_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && !any_in_ctl |=> init);   // R1
   AST_DLY_NEEDS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      init_dly |-> init);   // R3
   AST_DLY_DROPS_WITH_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(init) |-> !init_dly);   // R3
   AST_NONE_IN_CTL_POS: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && !any_in_ctl |=> fbk_out == $past(pos_max));   // R4
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_en |=> $stable(fbk_out) && $stable(init) && $stable(init_dly));   // R9
endmodule

// File: tb/sim_fo_fbk_select.sv
module sim_fo_fbk_select;
   localparam int DW = 16;
   localparam int SHOT = 2;
   localparam int DLY = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic exec_en = 1'b0;
   logic in_ctl = 1'b1, not_lo = 1'b1, not_hi = 1'b1, chg = 1'b0;
   logic signed [DW-1:0] fmax = '0, pmax = '0, pctl = '0, prim = '0;
   logic signed [DW-1:0] fbk_out;
   logic init, init_dly;

   int n_chk = 0, n_bad = 0;

   // model state, from the requirements
   logic m_prev = 1'b0;
   int   m_cnt = 0, m_on = 0;
   logic e_init = 1'b0, e_dly = 1'b0;
   logic signed [DW-1:0] e_fbk = '0;
   string e_tag = "R10";
   string i_tag = "R10";

   always #2.5 clk = ~clk;

   fo_fbk_select #(.DATA_W(DW), .FRAC_W(8), .SHOT_LEN(SHOT), .DLY_LEN(DLY)) u0 (
      .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .any_in_ctl(in_ctl),
      .any_not_lo(not_lo), .any_not_hi(not_hi), .ctl_chg(chg),
      .fbk_max(fmax), .pos_max(pmax), .pos_ctl_max(pctl), .prim_out(prim),
      .fbk_out(fbk_out), .init(init), .init_dly(init_dly)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_exec();
      logic rise, shot;
      rise = chg && !m_prev;
      shot = rise || (m_cnt != 0);
      if (rise) m_cnt = SHOT - 1;
      else if (m_cnt != 0) m_cnt--;
      m_prev = chg;
      e_init = shot || !in_ctl;
      i_tag  = !in_ctl ? "R1" : "R2";
      e_dly  = e_init && (m_on >= DLY);
      if (!e_init) m_on = 0;
      else if (m_on < DLY) m_on++;
      if (!in_ctl)               begin e_fbk = pmax; e_tag = "R4"; end
      else if (e_init && !e_dly) begin e_fbk = prim; e_tag = "R5"; end
      else if (e_dly)            begin e_fbk = pctl; e_tag = "R6"; end
      else if (not_lo && not_hi) begin e_fbk = prim; e_tag = "R7"; end
      else                       begin e_fbk = fmax; e_tag = "R8"; end
   endtask

   // one clock; inputs already set at the negedge before it
   task automatic step(input logic ex);
      exec_en = ex;
      @(posedge clk);
      if (ex) model_exec();
      @(negedge clk);
      if (ex) begin
         chk(e_tag, int'(fbk_out), int'(e_fbk));
         chk(i_tag, int'(init), int'(e_init));
         chk("R3", int'(init_dly), int'(e_dly));
      end else begin
         chk("R9 fbk", int'(fbk_out), int'(e_fbk));
         chk("R9 init", int'(init), int'(e_init));
         chk("R9 dly", int'(init_dly), int'(e_dly));
      end
      exec_en = 1'b0;
   endtask

   task automatic set_vals();
      fmax = DW'($urandom); pmax = DW'($urandom);
      pctl = DW'($urandom); prim = DW'($urandom);
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      set_vals();
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 fbk", int'(fbk_out), 0);
      chk("R10 init", int'(init), 0);
      chk("R10 dly", int'(init_dly), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // steady in control, not limited: R7
      step(1'b1); step(1'b1);
      // all at high limit: R8
      not_hi = 1'b0; set_vals(); step(1'b1);
      // single change edge: R2, R5 then R6, then back to R8
      chg = 1'b1; set_vals(); step(1'b1);
      chg = 1'b0; set_vals(); step(1'b0); step(1'b1);
      set_vals(); step(1'b1);
      // change held high: no retrigger (R2)
      chg = 1'b1; step(1'b1); set_vals(); step(1'b1); step(1'b1); step(1'b1);
      // retrigger inside the one-shot
      chg = 1'b0; step(1'b1);
      chg = 1'b1; step(1'b1); chg = 1'b0; step(1'b1);
      chg = 1'b1; step(1'b1); chg = 1'b0; step(1'b1); step(1'b1); step(1'b1);
      // none in control: R1, R4, delayed init follows (R3)
      in_ctl = 1'b0; set_vals(); step(1'b1); step(1'b1); step(1'b0); step(1'b1);
      in_ctl = 1'b1; not_hi = 1'b1; set_vals(); step(1'b1); step(1'b1);

      // random mix
      for (int i = 0; i < 3000; i++) begin
         in_ctl = ($urandom % 4) != 0;
         not_lo = ($urandom % 3) != 0;
         not_hi = ($urandom % 3) != 0;
         chg    = ($urandom % 4) == 0;
         set_vals();
         step(($urandom % 2) == 0);
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule